// File: doc/BRIEF.md
# Three-Stage Pipeline Hazard Controller

This block is the control logic for an in-order integer pipeline with three stages: a combined fetch/decode stage, an execute stage and a write-back stage. It owns the fetch program counter and the valid bit of each stage. It keeps the register indices of the instructions in flight. From them it produces the operand-source selects for the execute stage, and it turns a taken branch or jump into a fetch redirect plus a squash of the younger instructions.

Instruction and data memory always accept a request, so no stage ever waits and the block has no stall path. There is no valid/ready handshake at its edge either: every pin is a plain per-cycle control or status signal. The decoder drives the source and destination indices of the instruction in fetch/decode every cycle. The execute stage drives the branch-taken flag and the target. The register file takes its write strobe and address from this block. Each stage's valid bit gates any side effect of the instruction in that stage, such as a data-memory write or a trap.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, that edge clears `fd_valid`, `ex_valid` and `wb_valid` and loads `fetch_pc` with the parameter `RESET_VEC`. In the cycles that follow, `rf_we` stays 0 until a valid instruction reaches write-back.
- R2: In a cycle with no redirect, `fetch_pc` advances by 4 at the next edge.
- R3: A redirect happens when `ex_valid` and `ex_taken` are both 1 in a cycle. In that cycle `npc_sel` is 1; it is 0 when fetch is sequential. In the following cycle `fetch_pc` equals the `ex_target` presented with the redirect.
- R4: A redirect squashes exactly two younger slots. In that cycle `kill_fetch` is 1 and `kill_fd` equals `fd_valid`. In the next cycle `fd_valid` and `ex_valid` are both 0. One cycle later `ex_valid` is still 0, and `fd_valid` is 1 for the instruction at the target.
- R5: With no redirect, one instruction enters each stage per cycle. One cycle after reset ends `fd_valid` is 1, one cycle later `ex_valid` is 1, and one cycle after that `wb_valid` is 1.
- R6: `fwd_sel_a` (or `fwd_sel_b`) is 1, meaning the operand comes from the write-back result, when all of these hold: write-back is valid, its write enable is set, and its destination equals the first (or second) source index of the execute instruction. Otherwise it is 0, meaning the register file.
- R7: Register index 0 never produces a forwarding match, even when the write-back instruction names it as its destination with its write enable set.
- R8: An older instruction that was squashed, or whose write enable is 0, never forwards.
- R9: `rf_we` is 1 exactly when write-back holds a valid instruction whose write enable is set, and `rf_waddr` is then its destination. A squashed slot never writes.
- R10: `ex_taken` has no effect while `ex_valid` is 0: `fetch_pc` steps by 4 and no slot is killed.
- R11: Asserting `rst` in the middle of a run returns the block to the R1 state, whatever instructions are in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dec_rs1 | input | RAW | First source index of the instruction in fetch/decode |
| dec_rs2 | input | RAW | Second source index of the instruction in fetch/decode |
| dec_rd | input | RAW | Destination index of the instruction in fetch/decode |
| dec_wen | input | 1 | Register write enable of the instruction in fetch/decode |
| ex_taken | input | 1 | Branch or jump in execute is taken |
| ex_target | input | XLEN | Resolved target address from execute |
| fetch_pc | output | XLEN | Address issued to instruction memory this cycle |
| npc_sel | output | 1 | Next fetch source: 1 target, 0 sequential |
| fd_valid | output | 1 | Fetch/decode slot holds a live instruction |
| ex_valid | output | 1 | Execute slot holds a live instruction |
| wb_valid | output | 1 | Write-back slot holds a live instruction |
| kill_fd | output | 1 | Live fetch/decode instruction is squashed this cycle |
| kill_fetch | output | 1 | Fetch in flight this cycle is squashed |
| fwd_sel_a | output | 1 | Operand A source: 1 write-back result, 0 register file |
| fwd_sel_b | output | 1 | Operand B source: 1 write-back result, 0 register file |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | RAW | Register file write index |

## Verification
The hardest case to reach from the ports involves a squashed instruction whose indices would match. It has a write-back destination equal to a source of the next live instruction, or a taken flag arriving while execute holds a bubble. Both only arise in the cycles right after a redirect. The stimulus holds `ex_taken` high across consecutive cycles and keeps each squashed slot's destination equal to the next sources. A long random phase then draws register indices from only four values, so matches, index 0 and back-to-back redirects occur often next to each other.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic {
    OPND_FROM_RF = 1'b0,
    OPND_FROM_WB = 1'b1
  } opnd_src_e;

  typedef enum logic {
    NPC_SEQ    = 1'b0,
    NPC_TARGET = 1'b1
  } npc_sel_e;

endpackage

// File: rtl/hz_pc_steer.sv
module hz_pc_steer
  import hz_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter logic [XLEN-1:0] RESET_VEC = '0,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            redirect,
  input  logic [XLEN-1:0] target,
  output logic [XLEN-1:0] fetch_pc,
  output npc_sel_e        npc_sel
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_next;

  always_comb begin
    npc_sel = redirect ? NPC_TARGET : NPC_SEQ;
    pc_next = (npc_sel == NPC_TARGET) ? target : pc_q + STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_VEC;
    else     pc_q <= pc_next;
  end

  assign fetch_pc = pc_q;

  // R3
  redirect_lands_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (fetch_pc == $past(target)));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    !redirect |=> (fetch_pc == $past(fetch_pc) + STEP));

endmodule

// File: rtl/hz_stage_track.sv
module hz_stage_track #(
  parameter int unsigned RAW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           flush,
  input  logic [RAW-1:0] dec_rs1,
  input  logic [RAW-1:0] dec_rs2,
  input  logic [RAW-1:0] dec_rd,
  input  logic           dec_wen,
  output logic           fd_valid,
  output logic           ex_valid,
  output logic           wb_valid,
  output logic [RAW-1:0] ex_rs1,
  output logic [RAW-1:0] ex_rs2,
  output logic [RAW-1:0] wb_rd,
  output logic           wb_wen
);

  logic [RAW-1:0] ex_rd;
  logic           ex_wen;

  // Valid chain: squash the decode slot and the in-flight fetch on flush.
  always_ff @(posedge clk) begin
    if (rst) begin
      fd_valid <= 1'b0;
      ex_valid <= 1'b0;
      wb_valid <= 1'b0;
    end else begin
      fd_valid <= !flush;
      ex_valid <= fd_valid && !flush;
      wb_valid <= ex_valid;
    end
  end

  // Register indices travel alongside; valid bits gate their use.
  always_ff @(posedge clk) begin
    if (rst) begin
      ex_rs1 <= '0;
      ex_rs2 <= '0;
      ex_rd  <= '0;
      ex_wen <= 1'b0;
      wb_rd  <= '0;
      wb_wen <= 1'b0;
    end else begin
      ex_rs1 <= dec_rs1;
      ex_rs2 <= dec_rs2;
      ex_rd  <= dec_rd;
      ex_wen <= dec_wen;
      wb_rd  <= ex_rd;
      wb_wen <= ex_wen;
    end
  end

  // R4
  squash_pair_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!fd_valid && !ex_valid));

  // R5
  steady_flow_chk: assert property (@(posedge clk) disable iff (rst)
    (fd_valid && !flush) |=> ex_valid);

  // R9
  bubble_carry_chk: assert property (@(posedge clk) disable iff (rst)
    !ex_valid |=> !wb_valid);

endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_pkg::*;
#(
  parameter int unsigned RAW     = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_SRC-1:0][RAW-1:0]   src_idx,
  input  logic                          wb_valid,
  input  logic                          wb_wen,
  input  logic [RAW-1:0]                wb_rd,
  output opnd_src_e [NUM_SRC-1:0]       src_sel
);

  logic wb_live;
  assign wb_live = wb_valid && wb_wen && (wb_rd != '0);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_comb begin
      src_sel[g] = OPND_FROM_RF;
      if (wb_live && (wb_rd == src_idx[g])) src_sel[g] = OPND_FROM_WB;
    end

    // R7
    no_zero_fwd_chk: assert property (@(posedge clk) disable iff (rst)
      (src_sel[g] == OPND_FROM_WB) |-> (src_idx[g] != '0));

    // R8
    fwd_needs_live_chk: assert property (@(posedge clk) disable iff (rst)
      (src_sel[g] == OPND_FROM_WB) |-> (wb_valid && wb_wen));
  end

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned RAW        = 5,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_0000,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RAW-1:0]  dec_rs1,
  input  logic [RAW-1:0]  dec_rs2,
  input  logic [RAW-1:0]  dec_rd,
  input  logic            dec_wen,
  input  logic            ex_taken,
  input  logic [XLEN-1:0] ex_target,
  output logic [XLEN-1:0] fetch_pc,
  output logic            npc_sel,
  output logic            fd_valid,
  output logic            ex_valid,
  output logic            wb_valid,
  output logic            kill_fd,
  output logic            kill_fetch,
  output logic            fwd_sel_a,
  output logic            fwd_sel_b,
  output logic            rf_we,
  output logic [RAW-1:0]  rf_waddr
);

  localparam int unsigned NUM_SRC = 2;

  logic           flush;
  logic [RAW-1:0] ex_rs1, ex_rs2, wb_rd;
  logic           wb_wen;
  npc_sel_e       npc_sel_e_w;
  opnd_src_e [NUM_SRC-1:0] src_sel;
  logic [NUM_SRC-1:0][RAW-1:0] src_idx;

  // A taken flag only counts when execute holds a live instruction.
  assign flush = ex_valid && ex_taken;

  hz_pc_steer #(
    .XLEN      (XLEN),
    .RESET_VEC (RESET_VEC),
    .INSN_BYTES(INSN_BYTES)
  ) u_pc (
    .clk     (clk),
    .rst     (rst),
    .redirect(flush),
    .target  (ex_target),
    .fetch_pc(fetch_pc),
    .npc_sel (npc_sel_e_w)
  );

  hz_stage_track #(.RAW(RAW)) u_track (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .dec_rs1 (dec_rs1),
    .dec_rs2 (dec_rs2),
    .dec_rd  (dec_rd),
    .dec_wen (dec_wen),
    .fd_valid(fd_valid),
    .ex_valid(ex_valid),
    .wb_valid(wb_valid),
    .ex_rs1  (ex_rs1),
    .ex_rs2  (ex_rs2),
    .wb_rd   (wb_rd),
    .wb_wen  (wb_wen)
  );

  assign src_idx[0] = ex_rs1;
  assign src_idx[1] = ex_rs2;

  hz_fwd_unit #(.RAW(RAW), .NUM_SRC(NUM_SRC)) u_fwd (
    .clk     (clk),
    .rst     (rst),
    .src_idx (src_idx),
    .wb_valid(wb_valid),
    .wb_wen  (wb_wen),
    .wb_rd   (wb_rd),
    .src_sel (src_sel)
  );

  assign npc_sel    = (npc_sel_e_w == NPC_TARGET);
  assign kill_fetch = flush;
  assign kill_fd    = flush && fd_valid;
  assign fwd_sel_a  = (src_sel[0] == OPND_FROM_WB);
  assign fwd_sel_b  = (src_sel[1] == OPND_FROM_WB);
  assign rf_we      = wb_valid && wb_wen;
  assign rf_waddr   = wb_rd;

  // R4
  second_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !ex_valid ##1 !ex_valid);

  // R9
  killed_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (flush && fd_valid) |-> ##2 !rf_we);

  // R10
  dead_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (!ex_valid && fd_valid) |=> ex_valid);

endmodule

// File: tb/pipe_hazard_ctrl_tb.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_tb;

  localparam int XLEN = 32;
  localparam int RAW  = 5;
  localparam logic [31:0] RVEC = 32'h0000_1000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic [RAW-1:0] dec_rs1 = '0, dec_rs2 = '0, dec_rd = '0;
  logic dec_wen = 1'b0, ex_taken = 1'b0;
  logic [XLEN-1:0] ex_target = '0;
  logic [XLEN-1:0] fetch_pc;
  logic npc_sel, fd_valid, ex_valid, wb_valid, kill_fd, kill_fetch;
  logic fwd_sel_a, fwd_sel_b, rf_we;
  logic [RAW-1:0] rf_waddr;

  pipe_hazard_ctrl #(.XLEN(XLEN), .RAW(RAW), .RESET_VEC(RVEC)) u_dut (
    .clk(clk), .rst(rst), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
    .dec_rd(dec_rd), .dec_wen(dec_wen), .ex_taken(ex_taken),
    .ex_target(ex_target), .fetch_pc(fetch_pc), .npc_sel(npc_sel),
    .fd_valid(fd_valid), .ex_valid(ex_valid), .wb_valid(wb_valid),
    .kill_fd(kill_fd), .kill_fetch(kill_fetch), .fwd_sel_a(fwd_sel_a),
    .fwd_sel_b(fwd_sel_b), .rf_we(rf_we), .rf_waddr(rf_waddr)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model: a small in-flight record per stage, kept as integers.
  bit known = 1'b0;
  bit post_mid_reset = 1'b0;
  int m_pc;
  int m_v[3];      // 0 fetch/decode, 1 execute, 2 write-back
  int m_rs1[3], m_rs2[3], m_rd[3], m_wen[3];

  task automatic chk(string req, string sig, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, sig, act, exp);
    end
  endtask

  function automatic bit fwd_hit(int src);
    return (m_v[2] != 0) && (m_wen[2] != 0) && (m_rd[2] != 0) && (m_rd[2] == src);
  endfunction

  task automatic step(bit r, int rs1, int rs2, int rd, bit wen, bit tk, logic [31:0] tgt);
    bit redir;
    @(negedge clk);
    rst = r; dec_rs1 = RAW'(rs1); dec_rs2 = RAW'(rs2); dec_rd = RAW'(rd);
    dec_wen = wen; ex_taken = tk; ex_target = tgt;
    #1;
    if (known) begin
      redir = (m_v[1] != 0) && tk;
      if (rst_tag()) begin end
      chk(post_mid_reset ? "R1 R11" : "R2 R3 R10", "fetch_pc", fetch_pc, m_pc);
      chk("R3 R10", "npc_sel", npc_sel, redir);
      chk("R1 R4 R5", "fd_valid", fd_valid, m_v[0]);
      chk("R1 R4 R5", "ex_valid", ex_valid, m_v[1]);
      chk("R1 R5", "wb_valid", wb_valid, m_v[2]);
      chk("R4 R10", "kill_fetch", kill_fetch, redir);
      chk("R4", "kill_fd", kill_fd, redir && (m_v[0] != 0));
      chk("R6 R7 R8", "fwd_sel_a", fwd_sel_a, fwd_hit(m_rs1[1]));
      chk("R6 R7 R8", "fwd_sel_b", fwd_sel_b, fwd_hit(m_rs2[1]));
      chk("R1 R9", "rf_we", rf_we, (m_v[2] != 0) && (m_wen[2] != 0));
      if (rf_we) chk("R9", "rf_waddr", rf_waddr, m_rd[2]);
    end
    post_mid_reset = 1'b0;
    if (r) begin
      m_pc = RVEC;
      for (int s = 0; s < 3; s++) begin
        m_v[s] = 0; m_rs1[s] = 0; m_rs2[s] = 0; m_rd[s] = 0; m_wen[s] = 0;
      end
      known = 1'b1;
    end else begin
      redir = (m_v[1] != 0) && tk;
      m_pc = redir ? int'(tgt) : m_pc + 4;
      m_v[2] = m_v[1]; m_rd[2] = m_rd[1]; m_wen[2] = m_wen[1];
      m_v[1] = (m_v[0] != 0) && !redir;
      m_rs1[1] = rs1; m_rs2[1] = rs2; m_rd[1] = rd; m_wen[1] = wen;
      m_v[0] = !redir;
    end
  endtask

  function automatic bit rst_tag();
    return 1'b0;
  endfunction

  initial begin
    // R1: reset state
    repeat (3) step(1, 0, 0, 0, 0, 0, 0);
    // R5, R6: dependent chain flowing one per cycle
    for (int i = 0; i < 8; i++) step(0, 1, 1, 1, 1, 0, 0);
    // R7: destination index 0 must not forward
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 0, 0);
    // R8: write enable low must not forward
    step(0, 2, 3, 2, 0, 0, 0);
    step(0, 2, 2, 3, 1, 0, 0);
    step(0, 3, 2, 3, 1, 0, 0);
    step(0, 3, 3, 1, 1, 0, 0);
    // R3, R4, R10: taken held two cycles; second lands on a bubble
    step(0, 5, 5, 5, 1, 1, 32'h0000_0400);
    step(0, 5, 5, 5, 1, 1, 32'h0000_0800);
    step(0, 5, 5, 5, 1, 0, 0);
    for (int i = 0; i < 5; i++) step(0, 5, 5, 5, 1, 0, 0);
    // Random mix with a small index range
    for (int i = 0; i < 3000; i++)
      step(0, $urandom_range(3, 0), $urandom_range(3, 0), $urandom_range(3, 0),
           1'($urandom_range(1, 0)), ($urandom_range(7, 0) == 0),
           {$urandom_range(32'h3fff, 0), 2'b00});
    // R11: reset in the middle of traffic
    step(1, 1, 1, 1, 1, 1, 32'h40);
    post_mid_reset = 1'b1;
    step(1, 1, 1, 1, 1, 1, 32'h40);
    post_mid_reset = 1'b1;
    for (int i = 0; i < 40; i++)
      step(0, $urandom_range(3, 0), $urandom_range(3, 0), $urandom_range(3, 0),
           1'($urandom_range(1, 0)), ($urandom_range(5, 0) == 0),
           {$urandom_range(32'hff, 0), 2'b00});
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule